// File: doc/BRIEF.md
# Attention-Arbitrated Frame Transmitter

This block sends one buffered frame at a time onto a shared, half-duplex serial bus whose stations coordinate through a single open-drain attention line. A frame has four parts: a destination byte at buffer address 0, a length byte at buffer address 1, the payload, and a check byte. The frame is written into an internal byte buffer through a simple write port. A one-cycle send request then starts arbitration. The request succeeds only while the attention line, sampled through a synchronizer, reads high. On success the block pulls the line low and waits two bit periods. It then hands the frame bytes, one per valid/ready handshake, to an external byte serializer. The serializer runs at 19.2 kbit/s with 8 data bits, no parity and 2 stop bits.

After the last byte is taken, the block keeps the line claimed until the serializer reports that its shift register has fully drained. It then releases the line and counts the frame as sent. It refuses any new request until the released line has stayed high for a minimum hold time of 10 µs by default. A refused request returns a busy pulse and advances a busy counter. The bit period and the hold time are derived from the clock-frequency parameter.

The reset input is active low and asynchronous. Its release is expected to be synchronized upstream.

Top module: `attn_frame_tx`

## Requirements
- R1: After reset, `attn_oe`, `tx_valid`, `send_ack` and `send_busy` are 0, `link_idle` is 1, and both counters read 0.
- R2: A `send_req` sampled while `link_idle` is 1 and the synchronized line is high is accepted. One cycle later `send_ack` pulses for one cycle and `attn_oe` goes to 1.
- R3: A `send_req` that is not accepted, either because the line reads low through the synchronizer or because the block is not idle, produces a one-cycle `send_busy` pulse one cycle later. It also adds 1 to `busy_count` and leaves `attn_oe` unchanged.
- R4: After acceptance, `attn_oe` is 1 and `tx_valid` is 0 for exactly 2×BIT_CYC cycles before the first byte is offered, where BIT_CYC = round(CLK_HZ/BAUD).
- R5: The frame holds (value of buffer byte 1) + 3 bytes. They are offered in order from buffer address 0 upward.
- R6: One byte is transferred per cycle with both `tx_valid` and `tx_ready` high. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` stays stable.
- R7: After the last byte is taken, `tx_valid` is 0 and `attn_oe` stays 1 until `tx_done` is seen. A `tx_done` pulse seen while bytes remain is ignored.
- R8: One cycle after `tx_done` is seen in the drain phase, `attn_oe` is 0. One cycle after that, `sent_count` has advanced by 1.
- R9: After release, the block stays non-idle for HOLD_CYC + 1 cycles, where HOLD_CYC = ceil(CLK_HZ×HOLD_US/10^6). Requests in that window are refused as in R3.
- R10: Buffer writes made while `attn_oe` is 1 are ignored. The bytes sent keep the values loaded before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Buffer write strobe |
| ld_addr | input | ADDR_W | Buffer write address |
| ld_data | input | BYTE_W | Buffer write data |
| send_req | input | 1 | Request to send the buffered frame (one-cycle pulse) |
| send_ack | output | 1 | Request accepted (one-cycle pulse) |
| send_busy | output | 1 | Request refused (one-cycle pulse) |
| link_idle | output | 1 | Block is idle and can accept a request |
| attn_in | input | 1 | Sensed level of the shared attention line |
| attn_oe | output | 1 | Drive the attention line low (open-drain enable) |
| tx_data | output | BYTE_W | Byte offered to the serializer |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_ready | input | 1 | Serializer data register is empty and takes the byte |
| tx_done | input | 1 | Serializer shift register has fully drained |
| sent_count | output | CNT_W | Frames sent, wraps |
| busy_count | output | CNT_W | Requests refused, wraps |

## Verification
The bench builds the block with CLK_HZ = 1.92 MHz and BAUD = 19200, keeping HOLD_US = 10. That gives a 100-cycle bit, a 200-cycle claim window and a 20-cycle hold, so the exact claim length and hold length can be counted cycle by cycle within a short run. The buffer keeps its full default depth of 258 bytes, so both the empty-payload frame (3 bytes) and the longest frame (255-byte payload) are sent. These runs are mixed with random lengths, random serializer stalls, a competing station holding the line low, early drain reports, and buffer writes made mid-frame.

// File: rtl/attn_tx_pkg.sv
package attn_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLAIM = 3'd1,
    ST_SEND  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_SENT  = 3'd4,
    ST_HOLD  = 3'd5
  } tx_state_t;

  // destination byte + length byte + check byte
  localparam int unsigned FRAME_OVERHEAD = 3;
  // buffer position of the length byte
  localparam int unsigned LEN_POS = 1;

endpackage

// File: rtl/attn_tx_sync.sv
module attn_tx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= RESET_VAL;
        else        sr_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= {STAGES{RESET_VAL}};
        else        sr_q <= {sr_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/attn_tx_fbuf.sv
module attn_tx_fbuf #(
  parameter int unsigned DW      = 8,
  parameter int unsigned DEPTH   = 258,
  parameter int unsigned AW      = 9,
  parameter int unsigned LEN_POS = 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] len_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < AW'(DEPTH))) mem[wr_addr] <= wr_data;
  end

  assign rd_data  = (rd_addr < AW'(DEPTH)) ? mem[rd_addr] : '0;
  assign len_data = mem[LEN_POS];

endmodule

// File: rtl/attn_tx_timer.sv
module attn_tx_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/attn_frame_tx.sv
module attn_frame_tx
  import attn_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 8_000_000,
  parameter int unsigned BAUD        = 19_200,
  parameter int unsigned HOLD_US     = 10,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned ADDR_W      = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              send_req,
  output logic              send_ack,
  output logic              send_busy,
  output logic              link_idle,
  input  logic              attn_in,
  output logic              attn_oe,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic              tx_done,
  output logic [CNT_W-1:0]  sent_count,
  output logic [CNT_W-1:0]  busy_count
);

  localparam int unsigned DEPTH     = (1 << BYTE_W) - 1 + FRAME_OVERHEAD;
  localparam int unsigned BIT_CYC   = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int unsigned CLAIM_CYC = (2 * BIT_CYC == 0) ? 1 : 2 * BIT_CYC;
  localparam longint unsigned HOLD_RAW =
    (longint'(CLK_HZ) * longint'(HOLD_US) + 64'd999_999) / 64'd1_000_000;
  localparam int unsigned HOLD_CYC  = (HOLD_RAW == 0) ? 1 : int'(HOLD_RAW);
  localparam int unsigned TMR_MAX   = (CLAIM_CYC > HOLD_CYC) ? CLAIM_CYC : HOLD_CYC;
  localparam int unsigned TMR_W     = $clog2(TMR_MAX + 1);

  tx_state_t st_q, st_d;
  logic [ADDR_W-1:0] idx_q, idx_d, left_q, left_d;
  logic [BYTE_W-1:0] rd_byte, len_byte;
  logic              attn_s;
  logic              tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              req_ok, req_bad, hs, buf_we;
  logic              oe_d, oe_q, ack_q, busy_q;
  logic [CNT_W-1:0]  sent_q, bcnt_q;

  attn_tx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(attn_in), .q(attn_s)
  );

  attn_tx_fbuf #(.DW(BYTE_W), .DEPTH(DEPTH), .AW(ADDR_W), .LEN_POS(LEN_POS)) u_fbuf (
    .clk(clk), .wr_en(buf_we), .wr_addr(ld_addr), .wr_data(ld_data),
    .rd_addr(idx_q), .rd_data(rd_byte), .len_data(len_byte)
  );

  attn_tx_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .zero(tmr_zero)
  );

  assign tx_valid = (st_q == ST_SEND);
  assign hs       = tx_valid && tx_ready;
  assign req_ok   = send_req && (st_q == ST_IDLE) && attn_s;
  assign req_bad  = send_req && !req_ok;
  // loader is locked out while the line is claimed
  assign buf_we   = ld_we && !oe_q;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    left_d   = left_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_ok) begin
          st_d     = ST_CLAIM;
          idx_d    = '0;
          left_d   = ADDR_W'(len_byte) + ADDR_W'(FRAME_OVERHEAD);
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(CLAIM_CYC - 1);
        end
      end
      ST_CLAIM: begin
        if (tmr_zero) st_d = ST_SEND;
        else          tmr_dec = 1'b1;
      end
      ST_SEND: begin
        if (hs) begin
          idx_d  = idx_q + ADDR_W'(1);
          left_d = left_q - ADDR_W'(1);
          if (left_q == ADDR_W'(1)) st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (tx_done) st_d = ST_SENT;
      end
      ST_SENT: begin
        st_d     = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HOLD_CYC - 1);
      end
      ST_HOLD: begin
        if (tmr_zero) st_d = ST_IDLE;
        else          tmr_dec = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    oe_d = (st_d == ST_CLAIM) || (st_d == ST_SEND) || (st_d == ST_DRAIN);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      left_q <= '0;
      oe_q   <= 1'b0;
      ack_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      left_q <= left_d;
      oe_q   <= oe_d;
      ack_q  <= req_ok;
      busy_q <= req_bad;
    end
  end

  // event counters with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= '0;
      bcnt_q <= '0;
    end else begin
      if (st_q == ST_SENT) sent_q <= sent_q + CNT_W'(1);
      if (req_bad)         bcnt_q <= bcnt_q + CNT_W'(1);
    end
  end

  assign attn_oe    = oe_q;
  assign tx_data    = rd_byte;
  assign link_idle  = (st_q == ST_IDLE);
  assign send_ack   = ack_q;
  assign send_busy  = busy_q;
  assign sent_count = sent_q;
  assign busy_count = bcnt_q;

endmodule

// File: rtl/attn_frame_tx_chk.sv
module attn_frame_tx_chk #(
  parameter int unsigned CLK_HZ = 8_000_000,
  parameter int unsigned BAUD   = 19_200,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              send_ack,
  input logic              send_busy,
  input logic              attn_oe,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic [CNT_W-1:0]  sent_count,
  input logic [CNT_W-1:0]  busy_count
);

  localparam int unsigned BIT_CYC   = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int unsigned CLAIM_CYC = (2 * BIT_CYC == 0) ? 1 : 2 * BIT_CYC;

  int unsigned claim_cnt;
  logic        started;

  // cycles with the line claimed before the first byte is offered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_cnt <= 0;
      started   <= 1'b0;
    end else if (!attn_oe) begin
      claim_cnt <= 0;
      started   <= 1'b0;
    end else begin
      if (tx_valid) started <= 1'b1;
      if (!started && !tx_valid) claim_cnt <= claim_cnt + 1;
    end
  end

  p_ack_claims_r2: assert property (@(posedge clk) disable iff (!rst_n)
    send_ack |-> attn_oe);

  p_ack_busy_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_ack && send_busy));

  p_busy_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_busy |-> (busy_count == CNT_W'($past(busy_count) + 1'b1)));

  p_busy_no_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    send_busy |-> $stable(attn_oe));

  p_claim_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_oe && tx_valid && !started) |-> (claim_cnt == CLAIM_CYC));

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_quiet_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !attn_oe |-> !tx_valid);

  p_sent_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sent_count) |-> !attn_oe);

endmodule

bind attn_frame_tx attn_frame_tx_chk #(
  .CLK_HZ(CLK_HZ), .BAUD(BAUD), .CNT_W(CNT_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .send_ack(send_ack), .send_busy(send_busy),
  .attn_oe(attn_oe), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .sent_count(sent_count), .busy_count(busy_count)
);

// File: tb/attn_frame_tx_bench.sv
module attn_frame_tx_bench;

  localparam int unsigned CLK_HZ  = 1_920_000;
  localparam int unsigned BAUD    = 19_200;
  localparam int unsigned HOLD_US = 10;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic ld_we, send_req, tx_ready, tx_done, other_low;
  logic [ADDR_W-1:0] ld_addr;
  logic [BYTE_W-1:0] ld_data, tx_data;
  logic send_ack, send_busy, link_idle, attn_oe, tx_valid, attn_line;
  logic [CNT_W-1:0] sent_count, busy_count;

  int n_chk = 0, n_fail = 0;
  int sent_exp = 0, busy_exp = 0;
  logic [7:0] bmem [0:257];

  always #5 clk = ~clk;

  // open-drain wired-AND of this block and another station
  assign attn_line = !(attn_oe || other_low);

  attn_frame_tx #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .HOLD_US(HOLD_US),
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
  ) u_attn_frame_tx (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .send_req(send_req), .send_ack(send_ack), .send_busy(send_busy),
    .link_idle(link_idle), .attn_in(attn_line), .attn_oe(attn_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_done(tx_done),
    .sent_count(sent_count), .busy_count(busy_count)
  );

  function automatic int exp_total(input int len);
    return len + 3;
  endfunction

  function automatic int exp_claim();
    return 2 * ((CLK_HZ + BAUD / 2) / BAUD);
  endfunction

  function automatic int exp_hold();
    longint h;
    h = (longint'(CLK_HZ) * HOLD_US + 999_999) / 1_000_000;
    return (h == 0) ? 1 : int'(h);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic line_busy();
    @(negedge clk) other_low = 1'b1;
    repeat (3) @(negedge clk);
    send_req = 1'b1;
    @(negedge clk) send_req = 1'b0;
    busy_exp++;
    check(send_busy == 1'b1, "R3 busy on low line", int'(send_busy), 1);
    check(attn_oe == 1'b0, "R3 no claim on low line", int'(attn_oe), 0);
    check(int'(busy_count) == busy_exp, "R3 busy count", int'(busy_count), busy_exp);
    @(negedge clk);
    check(send_busy == 1'b0 && link_idle == 1'b1, "R3 busy single pulse",
          int'(send_busy), 0);
    other_low = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input int len, input bit poke, input bit early_done);
    int total, claim, got, d, idle_cnt;
    bit first, prev_v, prev_r, rdy;
    logic [7:0] prev_d;
    total = exp_total(len);
    for (int i = 0; i < total; i++) bmem[i] = 8'($urandom);
    bmem[1] = 8'(len);
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = ADDR_W'(i); ld_data = bmem[i];
    end
    @(negedge clk) ld_we = 1'b0;
    send_req = 1'b1;
    @(negedge clk) send_req = 1'b0;
    check(send_ack == 1'b1, "R2 ack", int'(send_ack), 1);
    check(attn_oe == 1'b1, "R2 claim", int'(attn_oe), 1);
    claim = 0; got = 0; first = 0; prev_v = 0; prev_r = 0; prev_d = '0;
    while (got < total) begin
      ld_we = 1'b0; tx_done = 1'b0;
      if (!first && tx_valid) begin
        first = 1;
        check(claim == exp_claim(), "R4 claim length", claim, exp_claim());
      end
      if (!first) claim++;
      if (prev_v && !prev_r)
        check(tx_valid == 1'b1 && tx_data == prev_d, "R6 stall hold",
              int'(tx_data), int'(prev_d));
      rdy = ($urandom % 4) != 0;
      tx_ready = rdy;
      if (tx_valid && rdy) begin
        check(tx_data == bmem[got], "R5 R10 byte", int'(tx_data), int'(bmem[got]));
        got++;
        if (poke && got == 2) begin
          ld_we = 1'b1; ld_addr = ADDR_W'(total - 1); ld_data = ~bmem[total - 1];
        end
        if (early_done && got == 1) tx_done = 1'b1;
      end
      prev_v = tx_valid; prev_r = rdy; prev_d = tx_data;
      @(negedge clk);
    end
    ld_we = 1'b0; tx_done = 1'b0; tx_ready = 1'b0;
    d = 1 + int'($urandom % 5);
    repeat (d) begin
      check(tx_valid == 1'b0 && attn_oe == 1'b1, "R7 drain hold", int'(attn_oe), 1);
      @(negedge clk);
    end
    tx_done = 1'b1;
    @(negedge clk) tx_done = 1'b0;
    check(attn_oe == 1'b0, "R8 release", int'(attn_oe), 0);
    idle_cnt = 1;
    sent_exp++;
    @(negedge clk);
    check(int'(sent_count) == sent_exp, "R8 sent count", int'(sent_count), sent_exp);
    while (!link_idle && idle_cnt < 1000) begin
      if (send_req) begin
        send_req = 1'b0;
        busy_exp++;
        check(send_busy == 1'b1 && attn_oe == 1'b0, "R9 refuse in hold",
              int'(send_busy), 1);
      end
      idle_cnt++;
      if (idle_cnt == 3) send_req = 1'b1;
      @(negedge clk);
    end
    check(idle_cnt == exp_hold() + 1, "R9 hold length", idle_cnt, exp_hold() + 1);
    check(int'(busy_count) == busy_exp, "R3 busy count", int'(busy_count), busy_exp);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0; send_req = 1'b0;
    tx_ready = 1'b0; tx_done = 1'b0; other_low = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(attn_oe == 1'b0 && tx_valid == 1'b0, "R1 outputs quiet", int'(attn_oe), 0);
    check(send_ack == 1'b0 && send_busy == 1'b0, "R1 no pulses", int'(send_ack), 0);
    check(link_idle == 1'b1, "R1 idle", int'(link_idle), 1);
    check(sent_count == '0 && busy_count == '0, "R1 counters",
          int'(sent_count), 0);
    repeat (3) @(negedge clk);

    run_frame(0, 1'b1, 1'b1);
    line_busy();
    run_frame(255, 1'b1, 1'b0);
    run_frame(1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      run_frame(int'($urandom % 40), (i % 2) == 0, (i % 3) == 0);
      if (i == 2) line_busy();
    end
    line_busy();
    finish_run();
  end

endmodule